// File: doc/BRIEF.md
# Ripple-Carry Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a scalar datapath. It accepts two operands and a four-bit mode code. It returns a result word together with a carry flag, a signed-overflow flag and a zero flag. The adder path is a chain of one-bit slices with a rippling carry. One negate control is shared by every subtracting mode. It inverts the second operand and injects a carry into bit 0, so a single adder serves addition, subtraction and both comparisons.

The comparisons are formed by subtracting. The outcome is routed from the most significant position back into bit 0 of the result, and all higher result bits are cleared. The zero flag reports an all-zero result, so equality can be tested by subtracting and looking at that flag. Logic modes and unused codes report no carry and no overflow.

Top module: `alu_core`

## Requirements
- R1: Mode 0 (add) and mode 1 (addu) give result = A + B modulo 2^WIDTH, with carry_o equal to the carry out of the top bit of that sum.
- R2: Mode 2 (sub) and mode 3 (subu) give result = A - B modulo 2^WIDTH. carry_o equals bit WIDTH of A + ~B + 1, which is 1 when no borrow occurs.
- R3: overflow_o can be 1 only in mode 0 and mode 2. In those modes it is 1 exactly when the true signed result does not fit in WIDTH bits. In modes 1 and 3 it is always 0.
- R4: In mode 0, operands of opposite sign never raise overflow_o. Two non-negative operands giving a negative sum raise it, and so do two negative operands giving a non-negative sum.
- R5: Modes 4, 5, 6 and 7 give the bitwise AND, OR, XOR and NOR of A and B, with carry_o = 0 and overflow_o = 0.
- R6: Mode 12 (signed less-than) gives result 1 when A < B as two's complement values and 0 otherwise, including when A - B overflows. Bits WIDTH-1 to 1 are 0, carry_o is the subtraction carry, and overflow_o is 0.
- R7: Mode 13 (unsigned less-than) gives result 1 when A < B as unsigned values and 0 otherwise. Bits WIDTH-1 to 1 are 0, carry_o is the subtraction carry, and overflow_o is 0.
- R8: zero_o is 1 exactly when every bit of result_o is 0, in every mode.
- R9: Mode codes 8, 9, 10, 11, 14 and 15 give result 0, carry_o 0 and overflow_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | WIDTH (32) | First operand |
| op_b_i | input | WIDTH (32) | Second operand, negated internally for subtracting modes |
| mode_i | input | 4 | Operation code |
| result_o | output | WIDTH (32) | Operation result |
| carry_o | output | 1 | Carry out of the top adder slice for arithmetic and compare modes |
| overflow_o | output | 1 | Signed overflow for add and sub |
| zero_o | output | 1 | Result is all zeros |

## Verification
The bench builds the block at its default width of 32 bits. At that width, the boundary operands are reachable: the most positive and most negative values, all-ones, and equal pairs. These operands exercise the full carry ripple, overflow in both directions, and signed compares whose subtraction overflows. Random operands from a fixed seed are run through every mode, including the unused codes. Each output is compared with a reference computed from wide arithmetic in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_ADD  = 4'd0,
    MODE_ADDU = 4'd1,
    MODE_SUB  = 4'd2,
    MODE_SUBU = 4'd3,
    MODE_AND  = 4'd4,
    MODE_OR   = 4'd5,
    MODE_XOR  = 4'd6,
    MODE_NOR  = 4'd7,
    MODE_SLT  = 4'd12,
    MODE_SLTU = 4'd13
  } alu_mode_e;

  typedef enum logic [2:0] {
    SEL_SUM,
    SEL_AND,
    SEL_OR,
    SEL_XOR,
    SEL_NOR,
    SEL_LTS,
    SEL_LTU,
    SEL_NONE
  } res_sel_e;

  typedef struct packed {
    logic     b_negate;
    logic     flag_carry;
    logic     flag_signed;
    res_sel_e sel;
  } alu_ctrl_t;

  function automatic alu_ctrl_t decode_mode(input logic [MODE_W-1:0] mode);
    alu_ctrl_t c;
    c = '{b_negate: 1'b0, flag_carry: 1'b0, flag_signed: 1'b0, sel: SEL_NONE};
    case (mode)
      MODE_ADD:  c = '{b_negate: 1'b0, flag_carry: 1'b1, flag_signed: 1'b1, sel: SEL_SUM};
      MODE_ADDU: c = '{b_negate: 1'b0, flag_carry: 1'b1, flag_signed: 1'b0, sel: SEL_SUM};
      MODE_SUB:  c = '{b_negate: 1'b1, flag_carry: 1'b1, flag_signed: 1'b1, sel: SEL_SUM};
      MODE_SUBU: c = '{b_negate: 1'b1, flag_carry: 1'b1, flag_signed: 1'b0, sel: SEL_SUM};
      MODE_AND:  c.sel = SEL_AND;
      MODE_OR:   c.sel = SEL_OR;
      MODE_XOR:  c.sel = SEL_XOR;
      MODE_NOR:  c.sel = SEL_NOR;
      MODE_SLT:  c = '{b_negate: 1'b1, flag_carry: 1'b1, flag_signed: 1'b0, sel: SEL_LTS};
      MODE_SLTU: c = '{b_negate: 1'b1, flag_carry: 1'b1, flag_signed: 1'b0, sel: SEL_LTU};
      default:   c.sel = SEL_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
  input  logic a_i,
  input  logic b_i,
  input  logic b_negate_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o
);

  logic b_eff;

  always_comb begin
    b_eff  = b_i ^ b_negate_i;
    sum_o  = a_i ^ b_eff ^ cin_i;
    cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
  end

endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_negate_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_msb_in_o,
  output logic             carry_out_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] carry;

  assign carry[0] = b_negate_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice i_slice (
      .a_i        (a_i[i]),
      .b_i        (b_i[i]),
      .b_negate_i (b_negate_i),
      .cin_i      (carry[i]),
      .sum_o      (sum_o[i]),
      .cout_o     (carry[i+1])
    );
  end

  assign carry_msb_in_o = carry[MSB];
  assign carry_out_o    = carry[WIDTH];

  // R2
  always_comb begin
    if (b_negate_i && (b_i == '0)) begin
      sub_zero_carry_chk: assert (carry_out_o && (sum_o == a_i))
        else $error("subtracting zero must carry out and keep A");
    end
  end

endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  res_sel_e         sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             set_signed_i,
  input  logic             set_unsigned_i,
  output logic [WIDTH-1:0] result_o
);

  localparam int PAD_W = WIDTH - 1;

  always_comb begin
    case (sel_i)
      SEL_SUM: result_o = sum_i;
      SEL_AND: result_o = a_i & b_i;
      SEL_OR:  result_o = a_i | b_i;
      SEL_XOR: result_o = a_i ^ b_i;
      SEL_NOR: result_o = ~(a_i | b_i);
      SEL_LTS: result_o = {{PAD_W{1'b0}}, set_signed_i};
      SEL_LTU: result_o = {{PAD_W{1'b0}}, set_unsigned_i};
      default: result_o = '0;
    endcase
  end

  // R6 R7
  always_comb begin
    if ((sel_i == SEL_LTS) || (sel_i == SEL_LTU)) begin
      slt_upper_clear_chk: assert (result_o[WIDTH-1:1] == '0)
        else $error("compare result has upper bits set");
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]  op_a_i,
  input  logic [WIDTH-1:0]  op_b_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              carry_o,
  output logic              overflow_o,
  output logic              zero_o
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] sum;
  logic             c_msb_in;
  logic             c_out;
  logic             ovf_raw;
  logic             set_signed;
  logic             set_unsigned;

  always_comb begin
    ctrl = decode_mode(mode_i);
  end

  alu_ripple_chain #(.WIDTH(WIDTH)) i_chain (
    .a_i            (op_a_i),
    .b_i            (op_b_i),
    .b_negate_i     (ctrl.b_negate),
    .sum_o          (sum),
    .carry_msb_in_o (c_msb_in),
    .carry_out_o    (c_out)
  );

  always_comb begin
    ovf_raw      = c_msb_in ^ c_out;
    set_signed   = sum[MSB] ^ ovf_raw;
    set_unsigned = ~c_out;
    carry_o      = ctrl.flag_carry & c_out;
    overflow_o   = ctrl.flag_signed & ovf_raw;
  end

  alu_result_sel #(.WIDTH(WIDTH)) i_sel (
    .sel_i          (ctrl.sel),
    .a_i            (op_a_i),
    .b_i            (op_b_i),
    .sum_i          (sum),
    .set_signed_i   (set_signed),
    .set_unsigned_i (set_unsigned),
    .result_o       (result_o)
  );

  assign zero_o = ~|result_o;

  // R4
  always_comb begin
    if ((mode_i == MODE_ADD) && (op_a_i[MSB] != op_b_i[MSB])) begin
      no_overflow_chk: assert (!overflow_o)
        else $error("opposite-sign add flagged overflow");
    end
  end

  // R3
  always_comb begin
    if ((mode_i != MODE_ADD) && (mode_i != MODE_SUB)) begin
      unsigned_no_ovf_chk: assert (!overflow_o)
        else $error("overflow raised outside signed add/sub");
    end
  end

  // R5 R9
  always_comb begin
    if (ctrl.sel inside {SEL_AND, SEL_OR, SEL_XOR, SEL_NOR, SEL_NONE}) begin
      logic_flags_clear_chk: assert (!carry_o && !overflow_o)
        else $error("logic or unused mode left a flag set");
    end
  end

  // R9
  always_comb begin
    if (ctrl.sel == SEL_NONE) begin
      unused_zero_chk: assert (zero_o)
        else $error("unused mode gave nonzero result");
    end
  end

endmodule

// File: tb/test_alu_core.sv
module test_alu_core;

  localparam int W = 32;

  logic clk;
  logic rst_n;
  logic [W-1:0] a, b;
  logic [3:0]   mode;
  logic [W-1:0] result;
  logic         carry, ovf, zero;

  int n_cmp;
  int n_bad;
  bit done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  alu_core #(.WIDTH(W)) i_alu_core (
    .op_a_i     (a),
    .op_b_i     (b),
    .mode_i     (mode),
    .result_o   (result),
    .carry_o    (carry),
    .overflow_o (ovf),
    .zero_o     (zero)
  );

  typedef struct packed {
    logic [W-1:0] res;
    logic         c;
    logic         v;
    logic         z;
  } exp_t;

  function automatic exp_t ref_alu(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [3:0] m);
    exp_t e;
    logic [W:0] s;
    e = '0;
    case (m)
      4'd0, 4'd1: begin
        s = {1'b0, x} + {1'b0, y};
        e.res = s[W-1:0];
        e.c = s[W];
        if (m == 4'd0) e.v = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
      end
      4'd2, 4'd3, 4'd12, 4'd13: begin
        s = {1'b0, x} + {1'b0, ~y} + 1;
        e.c = s[W];
        if (m == 4'd12)      e.res = ($signed(x) < $signed(y)) ? 1 : 0;
        else if (m == 4'd13) e.res = (x < y) ? 1 : 0;
        else                 e.res = s[W-1:0];
        if (m == 4'd2) e.v = (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
      end
      4'd4: e.res = x & y;
      4'd5: e.res = x | y;
      4'd6: e.res = x ^ y;
      4'd7: e.res = ~(x | y);
      default: e.res = '0;
    endcase
    e.z = (e.res == '0);
    return e;
  endfunction

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5";
      4'd12: return "R6";
      4'd13: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [3:0] m);
    exp_t e;
    string t;
    a = x; b = y; mode = m;
    @(negedge clk);
    e = ref_alu(x, y, m);
    t = tag_of(m);
    n_cmp++;
    if (result !== e.res || carry !== e.c) begin
      n_bad++;
      $display("FAIL %s mode=%0d a=%h b=%h: got res=%h c=%b exp res=%h c=%b",
               t, m, x, y, result, carry, e.res, e.c);
    end
    n_cmp++;
    if (ovf !== e.v) begin
      n_bad++;
      $display("FAIL R3 mode=%0d a=%h b=%h: got ovf=%b exp %b", m, x, y, ovf, e.v);
    end
    n_cmp++;
    if (zero !== e.z) begin
      n_bad++;
      $display("FAIL R8 mode=%0d a=%h b=%h: got zero=%b exp %b", m, x, y, zero, e.z);
    end
  endtask

  task automatic expect_ovf(input string t, input logic [W-1:0] x, input logic [W-1:0] y,
                            input logic v);
    a = x; b = y; mode = 4'd0;
    @(negedge clk);
    n_cmp++;
    if (ovf !== v) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h: got ovf=%b exp %b", t, x, y, ovf, v);
    end
  endtask

  localparam logic [W-1:0] MAXP = 32'h7fff_ffff;
  localparam logic [W-1:0] MINN = 32'h8000_0000;
  localparam logic [W-1:0] ONES = 32'hffff_ffff;

  initial begin
    int seed;
    n_cmp = 0; n_bad = 0; done = 0;
    rst_n = 1'b0;
    a = '0; b = '0; mode = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // reset-state style check: all-zero operands, add
    apply('0, '0, 4'd0);
    // R4 directed overflow cases
    expect_ovf("R4", MAXP, 32'd1, 1'b1);
    expect_ovf("R4", MINN, ONES, 1'b1);
    expect_ovf("R4", MAXP, ONES, 1'b0);
    expect_ovf("R4", MINN, 32'd5, 1'b0);
    expect_ovf("R4", MAXP, MINN, 1'b0);
    // directed corners over every mode code
    for (int m = 0; m < 16; m++) begin
      apply(MAXP, MINN, 4'(m));
      apply(MINN, MAXP, 4'(m));
      apply(MAXP, MAXP, 4'(m));
      apply(ONES, ONES, 4'(m));
      apply(ONES, 32'd1, 4'(m));
      apply(32'd0, ONES, 4'(m));
      apply(MINN, 32'd1, 4'(m));
      apply(32'h1234_5678, 32'h1234_5678, 4'(m));
    end
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x, y;
      x = $urandom;
      y = $urandom;
      if ((i % 8) == 0) y = x;
      apply(x, y, 4'($urandom % 16));
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule